// File: doc/BRIEF.md
# SPI Master Register Front End

This block sits between a simple 32-bit register bus and the serial engine of a byte-oriented SPI master. It holds a 64-byte transmit queue that software fills one byte per write, a 64-byte receive queue that software empties one byte per read, a control word, an interrupt enable word and an interrupt status word. The serial engine takes transmit bytes, delivers receive bytes and signals the end of an exchange. The front end raises a single interrupt line from the status and enable words.

Software uses it as follows. It flushes either queue through the control word, loads the transmit queue and sets the start bit. It then waits for the completion interrupt, collects the received bytes and acknowledges the interrupt by writing a one to the status bit. One packed level word gives both queue fill counts in a single read.

Top module: `spi_regfront`

## Requirements
- R1: After reset the control, enable and status words read 0, both levels are 0, `irq_o` and `xch_o` are low and a read of offset 0x00 returns 0.
- R2: A write to offset 0x04 with byte enable bit 0 set pushes `bus_wdata_i[7:0]` into the transmit queue. The engine pops the bytes in first-in-first-out order through `tx_pop_i`/`tx_data_o`. The transmit level reads in bits [22:16] of offset 0x28.
- R3: A push into a transmit queue holding 64 bytes is dropped, and the level stays at 64. Likewise, an engine push into a full receive queue is dropped.
- R4: `rx_push_i` stores `rx_data_i`. Each read of offset 0x00 returns the oldest byte in bits [7:0] and removes it. The receive level reads in bits [6:0] of offset 0x28.
- R5: A read of offset 0x00 while the receive queue is empty returns 0 and leaves the receive level unchanged.
- R6: Writing 1 to control bit 8 empties the transmit queue, and writing 1 to bit 9 empties the receive queue. Each bit acts alone and reads back 0. The other control bits, including bit 0 (enable) and bit 1 (master), are stored and appear on `ctl_word_o`.
- R7: Writing 1 to control bit 10 starts an exchange. `xch_o` and the read value of bit 10 stay 1 until `eng_done_i` and are not cleared by writing 0.
- R8: `eng_done_i` sets status bit 16 at offset 0x10. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R9: `irq_o` is high exactly when some status bit and its enable bit at offset 0x0c are both 1. Bit 16 of the enable word enables the completion interrupt.
- R10: The control, enable and status words update only the byte lanes whose `bus_be_i` bit is set. A write to offset 0x04 without byte lane 0 set pushes nothing.
- R11: When a start write or a status clear falls in the same cycle as `eng_done_i`, the set wins: `xch_o` stays 1, or status bit 16 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_be_i | input | 4 | Byte lane enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| ctl_word_o | output | 32 | Stored control word, bit 10 = exchange pending |
| xch_o | output | 1 | Exchange requested, held until done |
| eng_done_i | input | 1 | Engine pulse: exchange finished |
| tx_pop_i | input | 1 | Engine takes the head transmit byte |
| tx_data_o | output | 8 | Head transmit byte |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_level_o | output | 7 | Transmit fill count |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_full_o | output | 1 | Receive queue full |
| rx_level_o | output | 7 | Receive fill count |
| irq_o | output | 1 | Interrupt request |

## Verification
The transmit queue is filled from empty to full one byte at a time, with the level read after every push. It is then overfilled and drained, with bytes drawn from an arithmetic sequence, so a lost, duplicated or reordered byte or an off-by-one at the full boundary shows up. The receive queue gets the same sweep plus reads while empty. All sixteen byte-enable patterns are applied to the enable word so each lane's mask is told apart. All four combinations of status and enable are compared against the interrupt line. Each flush is run with both queues non-empty so a flush hitting the wrong queue stands out. Same-cycle completion against start and against clear separates set-wins from clear-wins.

// File: rtl/spi_regfront_pkg.sv
`timescale 1ns/1ps
package spi_regfront_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_RXD = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_TXD = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTL = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_IEN = 8'h0c;
  localparam logic [ADDR_W-1:0] OFF_STS = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_LVL = 8'h28;
  localparam int CB_TX_FLUSH = 8;
  localparam int CB_RX_FLUSH = 9;
  localparam int CB_GO       = 10;
  localparam int IB_DONE     = 16;
  localparam int LVL_TX_LSB  = 16;
endpackage

// File: rtl/spi_byte_fifo.sv
`timescale 1ns/1ps
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_irq_unit.sv
`timescale 1ns/1ps
module spi_irq_unit #(
  parameter int          DW       = 32,
  parameter int          DONE_BIT = 16,
  parameter logic [DW-1:0] IMPL   = DW'(1) << DONE_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ien_wr_i,
  input  logic          sts_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mask_i,
  input  logic          done_i,
  output logic [DW-1:0] ien_o,
  output logic [DW-1:0] sts_o,
  output logic          irq_o
);
  logic [DW-1:0] ien_q, sts_q, sts_d;

  always_comb begin
    sts_d = sts_q;
    if (sts_wr_i) sts_d = sts_d & ~(wdata_i & mask_i);
    if (done_i)   sts_d[DONE_BIT] = 1'b1;  // set beats clear
    sts_d = sts_d & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (ien_wr_i) ien_q <= (ien_q & ~mask_i) | (wdata_i & mask_i);
      sts_q <= sts_d;
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/spi_regfront.sv
`timescale 1ns/1ps
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int DW    = 32,
  localparam int BW    = 8,
  localparam int NB    = DW / BW,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NB-1:0]     bus_be_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [DW-1:0]     ctl_word_o,
  output logic              xch_o,
  input  logic              eng_done_i,
  input  logic              tx_pop_i,
  output logic [BW-1:0]     tx_data_o,
  output logic              tx_empty_o,
  output logic [CNT_W-1:0]  tx_level_o,
  input  logic              rx_push_i,
  input  logic [BW-1:0]     rx_data_i,
  output logic              rx_full_o,
  output logic [CNT_W-1:0]  rx_level_o
  ,output logic             irq_o
);
  logic [DW-1:0] mask, ctl_q, ien_w, sts_w;
  logic          go_q;
  logic          wr, rd, ctl_wr, txd_wr, rxd_rd;
  logic          tx_flush, rx_flush, tx_full_w, rx_empty_w;
  logic [BW-1:0] rx_head;

  always_comb begin
    for (int i = 0; i < NB; i++) mask[i*BW +: BW] = {BW{bus_be_i[i]}};
  end

  assign wr     = bus_sel_i && bus_we_i;
  assign rd     = bus_sel_i && !bus_we_i;
  assign ctl_wr = wr && (bus_addr_i == OFF_CTL);
  assign txd_wr = wr && (bus_addr_i == OFF_TXD) && bus_be_i[0];
  assign rxd_rd = rd && (bus_addr_i == OFF_RXD);

  assign tx_flush = ctl_wr && mask[CB_TX_FLUSH] && bus_wdata_i[CB_TX_FLUSH];
  assign rx_flush = ctl_wr && mask[CB_RX_FLUSH] && bus_wdata_i[CB_RX_FLUSH];

  localparam logic [DW-1:0] CTL_KEEP =
    ~((DW'(1) << CB_TX_FLUSH) | (DW'(1) << CB_RX_FLUSH) | (DW'(1) << CB_GO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      go_q  <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ((ctl_q & ~mask) | (bus_wdata_i & mask)) & CTL_KEEP;
      if (ctl_wr && mask[CB_GO] && bus_wdata_i[CB_GO]) go_q <= 1'b1;
      else if (eng_done_i)                              go_q <= 1'b0;
    end
  end

  assign ctl_word_o = ctl_q | (DW'(go_q) << CB_GO);
  assign xch_o      = go_q;

  spi_byte_fifo #(.DEPTH(DEPTH), .W(BW)) u_tx (
    .clk_i, .rst_ni,
    .flush_i (tx_flush),
    .push_i  (txd_wr),
    .data_i  (bus_wdata_i[BW-1:0]),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .level_o (tx_level_o),
    .full_o  (tx_full_w),
    .empty_o (tx_empty_o)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .W(BW)) u_rx (
    .clk_i, .rst_ni,
    .flush_i (rx_flush),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rxd_rd),
    .data_o  (rx_head),
    .level_o (rx_level_o),
    .full_o  (rx_full_o),
    .empty_o (rx_empty_w)
  );

  spi_irq_unit #(.DW(DW), .DONE_BIT(IB_DONE)) u_irq (
    .clk_i, .rst_ni,
    .ien_wr_i (wr && (bus_addr_i == OFF_IEN)),
    .sts_wr_i (wr && (bus_addr_i == OFF_STS)),
    .wdata_i  (bus_wdata_i),
    .mask_i   (mask),
    .done_i   (eng_done_i),
    .ien_o    (ien_w),
    .sts_o    (sts_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFF_RXD: bus_rdata_o = rx_empty_w ? '0 : DW'(rx_head);
      OFF_CTL: bus_rdata_o = ctl_word_o;
      OFF_IEN: bus_rdata_o = ien_w;
      OFF_STS: bus_rdata_o = sts_w;
      OFF_LVL: bus_rdata_o = (DW'(tx_level_o) << LVL_TX_LSB) | DW'(rx_level_o);
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_regfront_chk.sv
`timescale 1ns/1ps
module spi_regfront_chk
  import spi_regfront_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [3:0]        bus_be_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              xch_o,
  input logic              eng_done_i,
  input logic              tx_pop_i,
  input logic [CNT_W-1:0]  tx_level_o,
  input logic              rx_push_i,
  input logic [CNT_W-1:0]  rx_level_o,
  input logic              irq_o,
  input logic [31:0]       sts_i,
  input logic [31:0]       ien_i
);
  logic txd_wr, rxd_rd, go_wr, sts_clr;
  assign txd_wr  = bus_sel_i && bus_we_i && bus_addr_i == OFF_TXD && bus_be_i[0];
  assign rxd_rd  = bus_sel_i && !bus_we_i && bus_addr_i == OFF_RXD;
  assign go_wr   = bus_sel_i && bus_we_i && bus_addr_i == OFF_CTL && bus_be_i[1] && bus_wdata_i[CB_GO];
  assign sts_clr = bus_sel_i && bus_we_i && bus_addr_i == OFF_STS && bus_be_i[2] && bus_wdata_i[IB_DONE];

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level_o <= CNT_W'(DEPTH) && rx_level_o <= CNT_W'(DEPTH));

  a_r3_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_wr && tx_level_o == CNT_W'(DEPTH) && !tx_pop_i) |=> tx_level_o == CNT_W'(DEPTH));

  a_r5_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxd_rd && rx_level_o == '0) |-> bus_rdata_o == '0);

  a_r5_empty_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxd_rd && rx_level_o == '0 && !rx_push_i) |=> rx_level_o == '0);

  a_r7_go_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_wr |=> xch_o);

  a_r7_go_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xch_o && !eng_done_i) |=> xch_o);

  a_r8_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |=> sts_i[IB_DONE]);

  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr && !eng_done_i) |=> !sts_i[IB_DONE]);

  a_r9_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_i[IB_DONE] && ien_i[IB_DONE]));
endmodule

bind spi_regfront spi_regfront_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_be_i    (bus_be_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .xch_o       (xch_o),
  .eng_done_i  (eng_done_i),
  .tx_pop_i    (tx_pop_i),
  .tx_level_o  (tx_level_o),
  .rx_push_i   (rx_push_i),
  .rx_level_o  (rx_level_o),
  .irq_o       (irq_o),
  .sts_i       (sts_w),
  .ien_i       (ien_w)
);

// File: tb/tb_spi_regfront.sv
`timescale 1ns/1ps
module tb_spi_regfront;
  localparam int DEPTH = 64;
  localparam int CW = 7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 0, bus_we_i = 0;
  logic [7:0]  bus_addr_i = 0;
  logic [3:0]  bus_be_i = 0;
  logic [31:0] bus_wdata_i = 0;
  logic [31:0] bus_rdata_o, ctl_word_o;
  logic        xch_o, eng_done_i = 0, tx_pop_i = 0, tx_empty_o, rx_push_i = 0, rx_full_o, irq_o;
  logic [7:0]  tx_data_o, rx_data_i = 0;
  logic [CW-1:0] tx_level_o, rx_level_o;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk_i = ~clk_i;

  spi_regfront #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_be_i = be; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_sel_i = 0; bus_we_i = 0; bus_be_i = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_sel_i = 0;
  endtask

  task automatic wr_done(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_be_i = 4'hf; bus_wdata_i = d;
    eng_done_i = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_sel_i = 0; bus_we_i = 0; bus_be_i = 0; eng_done_i = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk_i); eng_done_i = 1;
    @(posedge clk_i);
    @(negedge clk_i); eng_done_i = 0;
  endtask

  task automatic tx_take(output logic [7:0] b);
    @(negedge clk_i); b = tx_data_o; tx_pop_i = 1;
    @(posedge clk_i);
    @(negedge clk_i); tx_pop_i = 0;
  endtask

  task automatic rx_give(logic [7:0] b);
    @(negedge clk_i); rx_push_i = 1; rx_data_i = b;
    @(posedge clk_i);
    @(negedge clk_i); rx_push_i = 0;
  endtask

  function automatic logic [7:0] ftx(int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] frx(int i); return 8'((i * 91 + 17) & 255); endfunction

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    rd(8'h08, d); chk("R1 ctl", d, 0);
    rd(8'h0c, d); chk("R1 ien", d, 0);
    rd(8'h10, d); chk("R1 sts", d, 0);
    rd(8'h28, d); chk("R1 lvl", d, 0);
    rd(8'h00, d); chk("R1 rxd", d, 0);
    chk("R1 irq/xch", {irq_o, xch_o}, 0);

    // R2 fill transmit queue with level sweep
    for (int i = 0; i < DEPTH; i++) begin
      wr(8'h04, 4'h1, {24'hABCDEF, ftx(i)});
      rd(8'h28, d); chk("R2 tx level", d, (i + 1) << 16);
    end
    // R3 overfill
    for (int i = 0; i < 3; i++) begin
      wr(8'h04, 4'h1, 32'h55);
      chk("R3 tx full level", tx_level_o, DEPTH);
    end
    // R2 drain in order
    for (int i = 0; i < DEPTH; i++) begin
      tx_take(b); chk("R2 tx order", b, ftx(i));
    end
    chk("R2 tx empty", {tx_empty_o, tx_level_o}, {1'b1, 7'd0});
    // R10 no lane 0 -> no push
    wr(8'h04, 4'he, 32'hFFFF_FF00);
    rd(8'h28, d); chk("R10 txd lane0 off", d, 0);

    // R4 receive sweep, R3 receive overfill
    for (int i = 0; i < DEPTH; i++) rx_give(frx(i));
    rx_give(8'hEE); rx_give(8'hEF);
    chk("R3 rx full", {rx_full_o, rx_level_o}, {1'b1, 7'd64});
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h00, d); chk("R4 rx order", d, frx(i));
      rd(8'h28, d); chk("R4 rx level", d, DEPTH - 1 - i);
    end
    // R5 empty reads
    for (int i = 0; i < 3; i++) begin
      rd(8'h00, d); chk("R5 empty data", d, 0);
      chk("R5 empty level", rx_level_o, 0);
    end

    // R6 independent flushes
    for (int i = 0; i < 5; i++) wr(8'h04, 4'h1, i);
    for (int i = 0; i < 7; i++) rx_give(8'(i));
    wr(8'h08, 4'hf, 32'h100);
    rd(8'h28, d); chk("R6 tx flush only", d, 7);
    rd(8'h08, d); chk("R6 flush bit reads 0", d, 0);
    wr(8'h04, 4'h1, 32'h9);
    wr(8'h08, 4'hf, 32'h200);
    rd(8'h28, d); chk("R6 rx flush only", d, 1 << 16);
    wr(8'h08, 4'hf, 32'h103);
    rd(8'h08, d); chk("R6 ctl stored", d, 3);
    chk("R6 ctl_word_o", ctl_word_o, 3);

    // R7 start bit
    wr(8'h08, 4'hf, 32'h403);
    chk("R7 xch set", xch_o, 1);
    wr(8'h08, 4'hf, 32'h003);
    rd(8'h08, d); chk("R7 go held", d, 32'h403);
    done_pulse();
    rd(8'h08, d); chk("R7 go cleared", d, 32'h003);
    chk("R7 xch low", xch_o, 0);

    // R8 status write-one-to-clear
    rd(8'h10, d); chk("R8 done set", d, 32'h1_0000);
    wr(8'h10, 4'hf, 32'h0);
    rd(8'h10, d); chk("R8 write 0 keeps", d, 32'h1_0000);
    wr(8'h10, 4'hb, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R10 sts lane2 off keeps", d, 32'h1_0000);
    wr(8'h10, 4'hf, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R8 all ones clears", d, 0);

    // R9 status x enable combinations
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 2; s++) begin
        wr(8'h10, 4'hf, 32'hFFFF_FFFF);
        wr(8'h0c, 4'hf, e ? 32'h1_0000 : 32'h0);
        if (s != 0) done_pulse();
        #1 chk("R9 irq", irq_o, (e & s));
      end
    end
    wr(8'h10, 4'hf, 32'hFFFF_FFFF);

    // R10 byte enable sweep on enable word
    for (int be = 0; be < 16; be++) begin
      logic [31:0] m;
      m = 0;
      for (int k = 0; k < 4; k++) if (be[k]) m[k*8 +: 8] = 8'hFF;
      wr(8'h0c, 4'hf, 32'h0);
      wr(8'h0c, 4'(be), 32'hFFFF_FFFF);
      rd(8'h0c, d); chk("R10 ien lanes", d, m);
    end
    wr(8'h0c, 4'hf, 32'h0);

    // R11 set wins over clear
    done_pulse();
    wr_done(8'h10, 32'h1_0000);
    rd(8'h10, d); chk("R11 sts set wins", d, 32'h1_0000);
    wr(8'h08, 4'hf, 32'h400);
    wr_done(8'h08, 32'h400);
    chk("R11 go set wins", xch_o, 1);
    done_pulse();
    chk("R11 go cleared after", xch_o, 0);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule